// File: doc/BRIEF.md
# Interrupt and DMA Request Steering Unit

This unit sits beside a serial bus protocol controller and decides where each of the controller's status flags goes. A six-bit mask register, read and written by software, holds one interrupt enable for each of the receive-full, lost-arbitration, end-of-data-minimum and end-of-frame-minimum flags, plus one DMA enable for each direction. When a direction's DMA enable is set, that direction's ready flag becomes a DMA request and stops raising interrupts. When the enable is clear, the flag goes to the shared interrupt line instead.

Two kinds of hardware event change the register on their own. An end-of-block pulse from a transaction counter clears the DMA enable of its direction, so that the flag goes back to the interrupt line. A controller disable that is held long enough clears the whole register. Disable pulses that are too short change nothing.

Top module: `irq_dma_steer`

## Requirements
- R1: A write stores `wr_data[5:0]` on the next clock edge. Bit 5 is the receive-full interrupt enable, bit 4 the lost-arbitration interrupt enable, bit 3 the receive DMA enable, bit 2 the end-of-data-minimum interrupt enable, bit 1 the end-of-frame-minimum interrupt enable and bit 0 the transmit DMA enable. `rd_data` shows the register in bits 5:0, and bits 7:6 always read as zero.
- R2: The lost-arbitration, end-of-data-minimum and end-of-frame-minimum flags each raise `irq` only while their enable bit is 1. The receive-full flag raises `irq` only while bit 5 is 1 and bit 3 is 0.
- R3: While bit 3 is 1, `rx_dma_req` follows `rx_full` and `rx_full` adds nothing to `irq`. While bit 3 is 0, `rx_dma_req` stays low.
- R4: While bit 0 is 0, `tx_ready` raises `irq` without any further enable and `tx_dma_req` stays low. While bit 0 is 1, `tx_dma_req` follows `tx_ready` and `tx_ready` adds nothing to `irq`.
- R5: An `rx_eob` pulse clears bit 3 on that clock edge and leaves the other bits as they were.
- R6: A `tx_eob` pulse clears bit 0 on that clock edge and leaves the other bits as they were.
- R7: When `ctl_disable` is high at 6 consecutive clock edges, bits 5:0 are zero after the sixth edge. They stay zero, and writes are ignored, for as long as `ctl_disable` remains high.
- R8: A `ctl_disable` run shorter than 6 edges leaves the register unchanged. Each low cycle restarts the count, so two runs of 5 edges with one low cycle between them change nothing.
- R9: `irq` is the OR of all enabled flag paths. It stays high for as long as any one of those paths is active.
- R10: When a write and an end-of-block clear hit the same bit on the same edge, the bit ends up 0. The other bits take the written value.
- R11: With `rst_n` low at a clock edge, the register becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 6 | Value written to the mask register |
| rd_data | output | 8 | Mask register readback, bits 7:6 zero |
| rx_full | input | 1 | Receive data register full flag |
| tx_ready | input | 1 | Transmitter ready flag |
| lost_arb | input | 1 | Transmitter lost arbitration flag |
| eod_min | input | 1 | End of data minimum flag |
| eof_min | input | 1 | End of frame minimum flag |
| rx_eob | input | 1 | Receive transaction counter end-of-block pulse |
| tx_eob | input | 1 | Transmit transaction counter end-of-block pulse |
| ctl_disable | input | 1 | Controller disable level |
| irq | output | 1 | Combined interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is the disable qualification. The clear depends on how long `ctl_disable` has been held, and nothing at the ports shows that count. The bench can only infer it from readback taken after exactly 5 edges and exactly 6 edges, and after a 5-edge run, a single low cycle and a second 5-edge run. A write issued while the disable is still held checks that the clear keeps priority. A write that lands on the same edge as an end-of-block pulse covers the priority between the two.

// File: rtl/steer_pkg.sv
// Package: shared mask layout for the request steering unit.
// Assumes: the bit order below is the order that software uses.
package steer_pkg;

    localparam int MASK_W = 6;

    // Packed MSB first, so field order matches bits 5 down to 0
    typedef struct packed {
        logic rx_irq_en;   // bit 5
        logic arb_irq_en;  // bit 4
        logic rx_dma_en;   // bit 3
        logic eod_irq_en;  // bit 2
        logic eof_irq_en;  // bit 1
        logic tx_dma_en;   // bit 0
    } mask_t;

endpackage

// File: rtl/hold_qualifier.sv
// Module: hold_qualifier
// Produces a clear strobe on every edge at which the input has been high
// for at least HOLD_CYCLES consecutive edges, counting the current one.
// Assumes: synchronous active-low reset; the input is already synchronous.
module hold_qualifier #(
    parameter int HOLD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic qualified
);
    generate
        if (HOLD_CYCLES <= 1) begin : g_direct
            // Without a hold window the level acts immediately
            assign qualified = level_in;
        end else begin : g_count
            localparam int CNT_W = $clog2(HOLD_CYCLES);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
            logic [CNT_W-1:0] run_cnt;

            // Count consecutive high edges, saturate at LAST, restart on low
            always_ff @(posedge clk) begin
                if (!rst_n || !level_in) run_cnt <= '0;
                else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
            end

            // Strobe when this edge completes the required run
            assign qualified = level_in && (run_cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/mask_reg.sv
// Module: mask_reg
// The six-bit mask register. A full clear beats everything else, an
// end-of-block clear beats a software write to the same bit.
// Assumes: synchronous active-low reset to all zeros.
module mask_reg
    import steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  mask_t wr_val,
    input  logic  rx_eob,
    input  logic  tx_eob,
    input  logic  clr_all,
    output mask_t q
);
    mask_t nxt;

    // Next-state selection with hardware clears applied last
    always_comb begin
        nxt = wr_en ? wr_val : q;
        if (rx_eob) nxt.rx_dma_en = 1'b0;
        if (tx_eob) nxt.tx_dma_en = 1'b0;
        if (clr_all) nxt = '0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/req_steer.sv
// Module: req_steer
// Combinational routing of the status flags to the interrupt line or to
// the DMA request lines, according to the mask.
// Assumes: flags are level signals that stay high until serviced.
module req_steer
    import steer_pkg::*;
(
    input  mask_t m,
    input  logic  rx_full,
    input  logic  tx_ready,
    input  logic  lost_arb,
    input  logic  eod_min,
    input  logic  eof_min,
    output logic  irq,
    output logic  rx_dma_req,
    output logic  tx_dma_req
);
    logic rx_irq_path, tx_irq_path, misc_irq_path;

    // Route each ready flag to exactly one destination
    always_comb begin
        rx_irq_path   = rx_full && m.rx_irq_en && !m.rx_dma_en;
        tx_irq_path   = tx_ready && !m.tx_dma_en;
        misc_irq_path = (lost_arb && m.arb_irq_en) ||
                        (eod_min  && m.eod_irq_en) ||
                        (eof_min  && m.eof_irq_en);
        irq        = rx_irq_path || tx_irq_path || misc_irq_path;
        rx_dma_req = rx_full  && m.rx_dma_en;
        tx_dma_req = tx_ready && m.tx_dma_en;
    end
endmodule

// File: rtl/irq_dma_steer.sv
// Module: irq_dma_steer (top)
// Mask register with software access, hardware clears and request steering.
// Assumes: single clock domain, synchronous active-low reset.
module irq_dma_steer
    import steer_pkg::*;
#(
    parameter int HOLD_CYCLES = 6,
    parameter int RD_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_data,
    output logic [RD_W-1:0]   rd_data,
    input  logic              rx_full,
    input  logic              tx_ready,
    input  logic              lost_arb,
    input  logic              eod_min,
    input  logic              eof_min,
    input  logic              rx_eob,
    input  logic              tx_eob,
    input  logic              ctl_disable,
    output logic              irq,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    localparam int PAD_W = RD_W - MASK_W;

    logic  clr_all;
    mask_t mask_q;

    hold_qualifier #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (ctl_disable),
        .qualified (clr_all)
    );

    mask_reg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_val  (mask_t'(wr_data)),
        .rx_eob  (rx_eob),
        .tx_eob  (tx_eob),
        .clr_all (clr_all),
        .q       (mask_q)
    );

    req_steer u_steer (
        .m          (mask_q),
        .rx_full    (rx_full),
        .tx_ready   (tx_ready),
        .lost_arb   (lost_arb),
        .eod_min    (eod_min),
        .eof_min    (eof_min),
        .irq        (irq),
        .rx_dma_req (rx_dma_req),
        .tx_dma_req (tx_dma_req)
    );

    // Readback with the unused upper bits tied low
    assign rd_data = {{PAD_W{1'b0}}, mask_q};
endmodule

// File: rtl/irq_dma_steer_chk.sv
// Module: irq_dma_steer_chk
// Port-level properties for irq_dma_steer, bound to every instance.
// Assumes: the same HOLD_CYCLES as the bound instance.
module irq_dma_steer_chk #(
    parameter int HOLD_CYCLES = 6,
    parameter int RD_W        = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [5:0]      wr_data,
    input logic [RD_W-1:0] rd_data,
    input logic            rx_full,
    input logic            tx_ready,
    input logic            lost_arb,
    input logic            eod_min,
    input logic            eof_min,
    input logic            rx_eob,
    input logic            tx_eob,
    input logic            ctl_disable,
    input logic            irq,
    input logic            rx_dma_req,
    input logic            tx_dma_req
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] held;

    // Independent count of consecutive disable edges, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_disable) held <= '0;
        else if (held != CW'(HOLD_CYCLES)) held <= held + 1'b1;
    end

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rx_eob && !tx_eob && !ctl_disable) |=> (rd_data[5:0] == $past(wr_data)));
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:6] == '0);
    p_arb_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_arb && rd_data[4]) |-> irq);
    p_rx_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_full && rd_data[3]));
    p_tx_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && rd_data[0]) |-> (tx_dma_req && !(irq && !rx_full && !lost_arb && !eod_min && !eof_min)));
    p_rx_eob_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eob |=> !rd_data[3]);
    p_tx_eob_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eob |=> !rd_data[0]);
    p_hold_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_disable && held >= CW'(HOLD_CYCLES - 1)) |=> (rd_data[5:0] == '0));
    p_eof_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_min && rd_data[1]) |-> irq);
endmodule

bind irq_dma_steer irq_dma_steer_chk #(.HOLD_CYCLES(HOLD_CYCLES), .RD_W(RD_W)) u_chk (.*);

// File: tb/sim_irq_dma_steer.sv
`timescale 1ns/1ps
module sim_irq_dma_steer;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic [7:0] rd_data;
    logic rx_full = 0, tx_ready = 0, lost_arb = 0, eod_min = 0, eof_min = 0;
    logic rx_eob = 0, tx_eob = 0, ctl_disable = 0;
    logic irq, rx_dma_req, tx_dma_req;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_dma_steer u0 (.*);

    // Vector: {mask[5:0], flags {rx_full,tx_ready,lost,eod,eof}, irq, rxd, txd}
    localparam logic [13:0] VEC [12] = '{
        {6'b000000, 5'b00000, 3'b000},   // R2 idle
        {6'b000000, 5'b01000, 3'b100},   // R4 tx_ready to irq
        {6'b000000, 5'b10111, 3'b000},   // R2 all masked
        {6'b100000, 5'b10000, 3'b100},   // R2 rx irq
        {6'b101000, 5'b10000, 3'b010},   // R3 rx to dma
        {6'b000001, 5'b01000, 3'b001},   // R4 tx to dma
        {6'b010000, 5'b00100, 3'b100},   // R2 arb
        {6'b000100, 5'b00010, 3'b100},   // R2 eod
        {6'b000010, 5'b00001, 3'b100},   // R2 eof
        {6'b000010, 5'b00110, 3'b000},   // R2 wrong pair masked
        {6'b001001, 5'b11000, 3'b011},   // R3 R4 both dma
        {6'b111111, 5'b00000, 3'b000}    // R9 no flags
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [5:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic dis_run(input int n);
        @(negedge clk); ctl_disable = 1'b1;
        repeat (n) @(negedge clk);
        ctl_disable = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset value", rd_data, 8'h00);
        chk("R11 reset outputs", {5'b0, irq, rx_dma_req, tx_dma_req}, 8'h00);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = VEC[i][13:8];
            {rx_full, tx_ready, lost_arb, eod_min, eof_min} = VEC[i][7:3];
            @(negedge clk); wr_en = 1'b0;
            chk("R1 readback", rd_data, {2'b00, VEC[i][13:8]});
            chk("R2 R3 R4 steering", {5'b0, irq, rx_dma_req, tx_dma_req}, {5'b0, VEC[i][2:0]});
        end
        {rx_full, tx_ready, lost_arb, eod_min, eof_min} = 5'b0;

        // R5 / R6 end-of-block clears
        write(6'h3F);
        @(negedge clk); rx_eob = 1'b1; @(negedge clk); rx_eob = 1'b0;
        chk("R5 rx_eob clears bit 3", rd_data, 8'h37);
        @(negedge clk); tx_eob = 1'b1; @(negedge clk); tx_eob = 1'b0;
        chk("R6 tx_eob clears bit 0", rd_data, 8'h36);

        // R10 write collides with hardware clear
        @(negedge clk); wr_en = 1'b1; wr_data = 6'h3F; rx_eob = 1'b1;
        @(negedge clk); wr_en = 1'b0; rx_eob = 1'b0;
        chk("R10 rx clear beats write", rd_data, 8'h37);
        @(negedge clk); wr_en = 1'b1; wr_data = 6'h3F; tx_eob = 1'b1;
        @(negedge clk); wr_en = 1'b0; tx_eob = 1'b0;
        chk("R10 tx clear beats write", rd_data, 8'h3E);

        // R8 short disable runs
        write(6'h3F);
        dis_run(5);
        chk("R8 five-edge run ignored", rd_data, 8'h3F);
        dis_run(5);
        chk("R8 count restarts after low", rd_data, 8'h3F);

        // R7 six-edge run clears and keeps clear
        @(negedge clk); ctl_disable = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 not yet cleared after 5", rd_data, 8'h3F);
        @(negedge clk);
        chk("R7 cleared after 6", rd_data, 8'h00);
        wr_en = 1'b1; wr_data = 6'h3F;
        @(negedge clk); wr_en = 1'b0;
        chk("R7 write ignored while held", rd_data, 8'h00);
        ctl_disable = 1'b0;
        write(6'h3F);
        chk("R7 writes resume after release", rd_data, 8'h3F);

        // R9 irq persists while any enabled pair is active
        write(6'b000110);
        eod_min = 1'b1; eof_min = 1'b1;
        @(negedge clk); eod_min = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 irq held by remaining pair", {7'b0, irq}, 8'h01);
        eof_min = 1'b0;
        @(negedge clk);
        chk("R9 irq drops when none active", {7'b0, irq}, 8'h00);

        // R11 reset in mid-run
        write(6'h3F);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 reset clears register", rd_data, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule